// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block places one 4-Kbyte window of on-chip peripheral registers anywhere in the address space, on a 4-Kbyte boundary. The window's position comes from a base register. Software can reach that register only through a special processor-space bus cycle, marked by a 4-bit function code of 7, at one fixed address (0x0003FF00). Ordinary accesses to that same address go to normal memory decoding and never touch the register.

On every strobed bus cycle that is not a processor-space cycle, the decoder compares the upper address bits with the stored base. When they match and the enable bit is set, it raises a select for the internal peripherals and passes on the low 12 address bits as the register offset. A processor-space cycle at the fixed address is acknowledged by the decoder itself. A read of the base register returns the stored base together with its enable bit.

Top module: `periph_window_decode`

## Requirements
- R1: After reset the stored base is 0 and the enable bit is 0. A processor-space read of the base register returns 0x00000000, and no peripheral select is raised.
- R2: A strobed processor-space write (function code 7, bus_rw=0) to address 0x0003FF00 loads the base from write data bits 31:12 and the enable bit from write data bit 0 at the clock edge. Write data bits 11:1 are discarded and always read back as 0.
- R3: A strobed processor-space read (bus_rw=1) of address 0x0003FF00 raises reg_ack in the same cycle. reg_rdata then carries the base in bits 31:12, the enable bit in bit 0 and zeros in bits 11:1. A read leaves the register unchanged.
- R4: A strobed write with any function code other than 7 leaves the base register unchanged, including a write to address 0x0003FF00.
- R5: A processor-space cycle to any address other than 0x0003FF00 raises neither reg_ack nor win_sel, and it does not change the register.
- R6: win_sel is 1 exactly when the strobe is high, the function code is not 7, the enable bit is 1 and bus address bits 31:12 equal the stored base. While win_sel is 1, win_offset equals bus address bits 11:0.
- R7: While the enable bit is 0, win_sel stays 0, even for an address inside the stored window.
- R8: With the strobe low, win_sel and reg_ack stay 0 and no write takes effect.
- R9: reg_rdata is 0 in every cycle in which there is no processor-space read of the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Bus address |
| bus_fc | input | 4 | Function code; 7 marks a processor-space cycle |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | Bus cycle valid |
| bus_wdata | input | 32 | Write data for the base register |
| win_sel | output | 1 | Select for the internal peripheral window |
| win_offset | output | 12 | Offset inside the window (address bits 11:0) |
| reg_rdata | output | 32 | Base register read data |
| reg_ack | output | 1 | Base register access acknowledge |

## Verification
The hardest case to reach is an ordinary data write to the register's own fixed address at a moment when the window has been moved to cover that address. The write must then select the peripheral window and must not touch the register. To get there, the stimulus first relocates the base to 0x0003F000 through a processor-space write, sends the data-space write, and reads the register back. The stimulus also loads write data with bits 11:1 set, to show that those bits are dropped, and it clears the enable bit while the base is nonzero, to show that a matching address is then ignored.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
   localparam int unsigned DEF_ADDR_W   = 32;
   localparam int unsigned DEF_WIN_BITS = 12;
   localparam int unsigned DEF_FC_W     = 4;

   // Decoded class of the current bus cycle
   typedef struct packed {
      logic cpu_space;   // strobed cycle with the processor-space code
      logic reg_hit;     // processor-space cycle at the register address
      logic reg_wr;      // register write
      logic reg_rd;      // register read
      logic data_space;  // strobed cycle in an ordinary space
   } pwd_access_t;
endpackage

// File: rtl/pwd_access_classify.sv
module pwd_access_classify
   import pwd_pkg::*;
#(
   parameter int unsigned       ADDR_W   = DEF_ADDR_W,
   parameter int unsigned       FC_W     = DEF_FC_W,
   parameter logic [FC_W-1:0]   CPU_FC   = 4'd7,
   parameter logic [ADDR_W-1:0] REG_ADDR = 32'h0003_FF00
) (
   input  logic              strobe,
   input  logic [FC_W-1:0]   fc,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rw,
   output pwd_access_t       acc
);
   logic is_cpu;
   logic at_reg;

   always_comb begin
      is_cpu         = (fc == CPU_FC);
      at_reg         = (addr == REG_ADDR);
      acc.cpu_space  = strobe && is_cpu;
      acc.data_space = strobe && !is_cpu;
      acc.reg_hit    = acc.cpu_space && at_reg;
      acc.reg_wr     = acc.reg_hit && !rw;
      acc.reg_rd     = acc.reg_hit && rw;
   end
endmodule

// File: rtl/pwd_base_reg.sv
module pwd_base_reg #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned WIN_BITS  = 12,
   parameter int unsigned VALID_BIT = 0,
   localparam int unsigned BASE_W   = ADDR_W - WIN_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wdata,
   output logic [BASE_W-1:0] base_q,
   output logic              valid_q,
   output logic [ADDR_W-1:0] rb_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         valid_q <= 1'b0;
      end else if (wr_en) begin
         base_q  <= wdata[ADDR_W-1:WIN_BITS];
         valid_q <= wdata[VALID_BIT];
      end
   end

   // Readback image: base on top, enable at its bit, zeros elsewhere
   for (genvar b = 0; b < WIN_BITS; b++) begin : g_low
      if (b == VALID_BIT) begin : g_en
         assign rb_word[b] = valid_q;
      end else begin : g_zero
         assign rb_word[b] = 1'b0;
      end
   end
   assign rb_word[ADDR_W-1:WIN_BITS] = base_q;
endmodule

// File: rtl/pwd_window_match.sv
module pwd_window_match #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned WIN_BITS = 12,
   localparam int unsigned BASE_W  = ADDR_W - WIN_BITS
) (
   input  logic                data_cycle,
   input  logic                enabled,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [BASE_W-1:0]   base,
   output logic                sel,
   output logic [WIN_BITS-1:0] offset
);
   logic page_eq;

   always_comb begin
      page_eq = (addr[ADDR_W-1:WIN_BITS] == base);
      sel     = data_cycle && enabled && page_eq;
      offset  = addr[WIN_BITS-1:0];
   end
endmodule

// File: rtl/periph_window_decode.sv
module periph_window_decode
   import pwd_pkg::*;
#(
   parameter int unsigned       ADDR_W    = DEF_ADDR_W,
   parameter int unsigned       WIN_BITS  = DEF_WIN_BITS,
   parameter int unsigned       FC_W      = DEF_FC_W,
   parameter logic [FC_W-1:0]   CPU_FC    = 4'd7,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 32'h0003_FF00,
   parameter int unsigned       VALID_BIT = 0,
   localparam int unsigned      BASE_W    = ADDR_W - WIN_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [FC_W-1:0]     bus_fc,
   input  logic                bus_rw,
   input  logic                bus_strobe,
   input  logic [ADDR_W-1:0]   bus_wdata,
   output logic                win_sel,
   output logic [WIN_BITS-1:0] win_offset,
   output logic [ADDR_W-1:0]   reg_rdata,
   output logic                reg_ack
);
   // Elaboration-time parameter checks
   if (WIN_BITS < 1 || WIN_BITS >= ADDR_W) begin : g_bad_win
      $error("WIN_BITS must lie between 1 and ADDR_W-1");
   end
   if (VALID_BIT >= WIN_BITS) begin : g_bad_valid
      $error("VALID_BIT must sit below the window boundary");
   end

   pwd_access_t       acc;
   logic [BASE_W-1:0] base_q;
   logic              valid_q;
   logic [ADDR_W-1:0] rb_word;

   pwd_access_classify #(
      .ADDR_W(ADDR_W), .FC_W(FC_W), .CPU_FC(CPU_FC), .REG_ADDR(REG_ADDR)
   ) u_class (
      .strobe (bus_strobe),
      .fc     (bus_fc),
      .addr   (bus_addr),
      .rw     (bus_rw),
      .acc    (acc)
   );

   pwd_base_reg #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .VALID_BIT(VALID_BIT)
   ) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc.reg_wr),
      .wdata   (bus_wdata),
      .base_q  (base_q),
      .valid_q (valid_q),
      .rb_word (rb_word)
   );

   pwd_window_match #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
   ) u_match (
      .data_cycle (acc.data_space),
      .enabled    (valid_q),
      .addr       (bus_addr),
      .base       (base_q),
      .sel        (win_sel),
      .offset     (win_offset)
   );

   always_comb begin
      reg_ack   = acc.reg_hit;
      reg_rdata = acc.reg_rd ? rb_word : '0;
   end
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
   parameter int unsigned       ADDR_W   = 32,
   parameter int unsigned       WIN_BITS = 12,
   parameter int unsigned       FC_W     = 4,
   parameter logic [FC_W-1:0]   CPU_FC   = 4'd7,
   parameter logic [ADDR_W-1:0] REG_ADDR = 32'h0003_FF00,
   localparam int unsigned      BASE_W   = ADDR_W - WIN_BITS
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [FC_W-1:0]   bus_fc,
   input logic              bus_rw,
   input logic              bus_strobe,
   input logic              win_sel,
   input logic [ADDR_W-1:0] reg_rdata,
   input logic              reg_ack,
   input logic [BASE_W-1:0] base_q,
   input logic              valid_q
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (base_q == '0) && !valid_q);                         // R1
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_strobe |-> !win_sel && !reg_ack);                         // R8
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_strobe |=> $stable(base_q) && $stable(valid_q));          // R8
   AST_CPU_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_strobe && bus_fc == CPU_FC) |-> !win_sel);                // R5
   AST_OTHER_ADDR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != REG_ADDR) |-> !reg_ack);                          // R5
   AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      win_sel |-> valid_q && (bus_addr[ADDR_W-1:WIN_BITS] == base_q)); // R6
   AST_DISABLED_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> !win_sel);                                        // R7
   AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_ack || !bus_rw) |-> (reg_rdata == '0));                  // R9
   AST_DATA_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_strobe && bus_fc != CPU_FC) |=> $stable(base_q) && $stable(valid_q)); // R4
   AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_strobe && bus_rw) |=> $stable(base_q) && $stable(valid_q)); // R3
endmodule

bind periph_window_decode pwd_checker #(
   .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .FC_W(FC_W),
   .CPU_FC(CPU_FC), .REG_ADDR(REG_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_fc     (bus_fc),
   .bus_rw     (bus_rw),
   .bus_strobe (bus_strobe),
   .win_sel    (win_sel),
   .reg_rdata  (reg_rdata),
   .reg_ack    (reg_ack),
   .base_q     (base_q),
   .valid_q    (valid_q)
);

// File: tb/periph_window_decode_tb.sv
module periph_window_decode_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] REG_A = 32'h0003_FF00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [3:0]  bus_fc = '0;
   logic        bus_rw = 1'b1;
   logic        bus_strobe = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        win_sel;
   logic [11:0] win_offset;
   logic [31:0] reg_rdata;
   logic        reg_ack;

   always #(CLK_PERIOD/2) clk = ~clk;

   periph_window_decode u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_fc(bus_fc),
      .bus_rw(bus_rw), .bus_strobe(bus_strobe), .bus_wdata(bus_wdata),
      .win_sel(win_sel), .win_offset(win_offset),
      .reg_rdata(reg_rdata), .reg_ack(reg_ack)
   );

   typedef struct {
      logic        sel;
      logic [11:0] off;
      logic        ack;
      logic [31:0] rd;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [19:0] m_base = '0;
   logic        m_en = 1'b0;

   // Driver: applies one bus cycle after a rising edge and queues the expected result
   task automatic cycle(input logic stb, input logic [3:0] fc, input logic [31:0] a,
                        input logic rw, input logic [31:0] wd, input string tag);
      exp_t e;
      logic cpu, hit;
      @(posedge clk);
      #1;
      bus_strobe = stb; bus_fc = fc; bus_addr = a; bus_rw = rw; bus_wdata = wd;
      cpu   = stb && (fc == 4'd7);
      hit   = cpu && (a == REG_A);
      e.ack = hit;
      e.rd  = (hit && rw) ? {m_base, 11'b0, m_en} : 32'h0;
      e.sel = stb && !cpu && m_en && (a[31:12] == m_base);
      e.off = a[11:0];
      e.tag = tag;
      sb.push_back(e);
      if (hit && !rw) begin
         m_base = wd[31:12];
         m_en   = wd[0];
      end
   endtask

   // Monitor: compares at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (win_sel !== e.sel || reg_ack !== e.ack || reg_rdata !== e.rd ||
                (e.sel && win_offset !== e.off)) begin
               errors++;
               $display("FAIL %s: sel=%0b off=%h ack=%0b rd=%h expected sel=%0b off=%h ack=%0b rd=%h",
                        e.tag, win_sel, win_offset, reg_ack, reg_rdata,
                        e.sel, e.off, e.ack, e.rd);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      cycle(1, 4'd7, REG_A, 1, 0, "R1 reset readback");
      // R7 / R1: disabled window at base 0
      cycle(1, 4'd5, 32'h0000_0123, 1, 0, "R7 disabled no select");
      // R8: unstrobed write is ignored
      cycle(0, 4'd7, REG_A, 0, 32'hFFFF_FFFF, "R8 no strobe");
      cycle(1, 4'd7, REG_A, 1, 0, "R8 readback after idle write");
      // R2 / R3: program base, low bits discarded
      cycle(1, 4'd7, REG_A, 0, 32'h1234_5FFF, "R2 program base");
      cycle(1, 4'd7, REG_A, 1, 0, "R3 readback base");
      // R6: window hits and misses
      cycle(1, 4'd5, 32'h1234_5ABC, 1, 0, "R6 hit read");
      cycle(1, 4'd1, 32'h1234_5000, 0, 0, "R6 hit write lowest");
      cycle(1, 4'd2, 32'h1234_5FFF, 1, 0, "R6 hit highest");
      cycle(1, 4'd5, 32'h1234_6000, 1, 0, "R6 miss above");
      cycle(1, 4'd5, 32'h1234_4FFF, 1, 0, "R6 miss below");
      // R4: data-space write to the register address
      cycle(1, 4'd1, REG_A, 0, 32'h0000_0000, "R4 data write");
      cycle(1, 4'd7, REG_A, 1, 0, "R4 readback unchanged");
      // R5: processor space elsewhere
      cycle(1, 4'd7, 32'h0003_FF04, 0, 32'h0, "R5 other cpu addr write");
      cycle(1, 4'd7, 32'h1234_5ABC, 1, 0, "R5 cpu space in window");
      cycle(1, 4'd7, REG_A, 1, 0, "R5 readback unchanged");
      // R4 corner: window covers the register address
      cycle(1, 4'd7, REG_A, 0, 32'h0003_F001, "R2 relocate over register");
      cycle(1, 4'd1, REG_A, 0, 32'h0000_0000, "R4 data write hits window");
      cycle(1, 4'd7, REG_A, 1, 0, "R4 readback after window write");
      // R7: enable cleared with nonzero base
      cycle(1, 4'd7, REG_A, 0, 32'hABCD_E000, "R7 disable");
      cycle(1, 4'd7, REG_A, 1, 0, "R7 readback disabled");
      cycle(1, 4'd5, 32'hABCD_E010, 1, 0, "R7 no select when disabled");
      // R9: write cycle gives no read data
      cycle(1, 4'd7, REG_A, 0, 32'hABCD_E001, "R9 write has zero rdata");
      cycle(1, 4'd5, 32'hABCD_E010, 1, 0, "R6 reenabled hit");
      cycle(0, 4'd0, 32'h0, 1, 0, "R8 idle");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule